// File: doc/BRIEF.md
# Protection Region Bounds Decoder and Matcher

This block takes a bank of memory-protection region descriptors and decides, in the same cycle, which region an access belongs to. Each region has a 2-bit matching mode and an address register that holds a byte address shifted right by two. From the mode, its own address register and the address register of the region just below it, every region works out an inclusive byte range `[lo, hi]`. The block then tests the first and last byte of the access against each region.

Regions are scanned from index 0 upward, and the scan stops at the first enabled region that holds either end of the access. If that region holds both ends, the access is a full match. If it holds only one end, the access straddles the region's edge and is reported as a partial overlap, which the permission stage treats as a violation. If no enabled region holds either end, the block reports no match. Permission evaluation is done elsewhere. This block supplies only the region index and the verdict.

All logic is combinational. A permission checker downstream can use the result in the same cycle as the access.

Top module: `prot_region_matcher`

## Requirements
- R1: A region whose mode field is 0 (off) never matches and never produces a partial overlap. With every region off, the verdict is no-match.
- R2: Mode 1 (top-of-range) covers bytes `prev << 2` through `(this << 2) - 1`. `prev` is the address register of region i-1, whether or not that region is enabled. For region 0, `prev` is 0. When `this` is 0, the end wraps to the all-ones byte address.
- R3: In top-of-range mode, if the computed start is above the computed end, both bounds become 0. The region then covers byte address 0 only.
- R4: Mode 2 (naturally aligned four bytes) covers bytes `this << 2` through `(this << 2) + 3`.
- R5: Mode 3 (naturally aligned power of two) sets `t = (this << 2) | 3` and covers bytes `t & (t+1)` through `t | (t+1)`. With k trailing ones in `this`, the region spans `8 << k` bytes.
- R6: The access covers bytes `acc_addr` through `acc_addr + acc_len_m1`, with the sum taken modulo 2^(AW+2). Both end bytes are tested against each region.
- R7: If exactly one end byte lies inside an enabled region, the scan stops there. The block raises `hit_partial` with that region's index.
- R8: The lowest-indexed enabled region that holds at least one end byte decides the result. Higher regions are ignored even if they would fully match.
- R9: Exactly one of `hit_full`, `hit_partial` and `hit_none` is high. `hit_idx` is 0 when `hit_none` is high.
- R10: The outputs follow the inputs in the same cycle, with no register on the path.

Field layout: region i's mode is `rgn_mode[2i+1:2i]` and its address register is `rgn_addr[AW*i +: AW]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rgn_addr | input | NREG*AW | Packed address registers. Region i is at `[AW*i +: AW]`. |
| rgn_mode | input | 2*NREG | Packed mode fields (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two). Region i is at `[2i +: 2]`. |
| acc_addr | input | AW+2 | Byte address of the first byte of the access. |
| acc_len_m1 | input | AW+2 | Access length in bytes minus one. |
| hit_idx | output | $clog2(NREG) | Index of the deciding region, or 0 when there is no match. |
| hit_full | output | 1 | Both end bytes lie inside the deciding region. |
| hit_partial | output | 1 | Only one end byte lies inside the deciding region. |
| hit_none | output | 1 | No enabled region holds either end byte. |

## Verification
A wrong bound in one region shows up at the ports in the same cycle as the access. It appears as a flipped verdict, either full versus partial or partial versus none, when an access end falls exactly on the corrupted edge. For that reason the directed cases place both the first and the last byte exactly on and one past every decoded edge. A broken priority chain shows up only when two regions overlap. Several cases therefore stack a small low-index region over a larger one and expect the smaller index to win, including when the lower region yields only a partial overlap. The random phase mixes all four modes over a narrow address window, so that overlaps, inverted top-of-range pairs and edge straddles occur often. Each cycle is compared with a behavioural model.

// File: rtl/prm_pkg.sv
package prm_pkg;

    // Matching mode carried in each region's 2-bit field.
    typedef enum logic [1:0] {
        RM_OFF   = 2'd0,
        RM_TOR   = 2'd1,
        RM_NA4   = 2'd2,
        RM_NAPOT = 2'd3
    } rmode_e;

    // Outcome of the scan.
    typedef enum logic [1:0] {
        VD_NONE = 2'd0,
        VD_FULL = 2'd1,
        VD_PART = 2'd2
    } verdict_e;

    // Per-region result of testing the two end bytes of an access.
    typedef struct packed {
        logic live;      // region enabled
        logic first_in;  // first byte inside
        logic last_in;   // last byte inside
    } probe_t;

    // A region stops the scan when it is enabled and holds either end.
    function automatic logic probe_stops(probe_t p);
        return p.live && (p.first_in || p.last_in);
    endfunction

    // Verdict given by a region that stops the scan.
    function automatic verdict_e probe_verdict(probe_t p);
        if (!probe_stops(p)) begin
            return VD_NONE;
        end
        return (p.first_in && p.last_in) ? VD_FULL : VD_PART;
    endfunction

endpackage

// File: rtl/prm_bounds_decoder.sv
module prm_bounds_decoder
    import prm_pkg::*;
#(
    parameter int AW = 32
) (
    input  rmode_e          mode,
    input  logic [AW-1:0]   this_addr,
    input  logic [AW-1:0]   prev_addr,
    output logic            live,
    output logic [AW+1:0]   lo,
    output logic [AW+1:0]   hi
);
    localparam int BW = AW + 2;

    logic [BW-1:0] tor_lo;
    logic [BW-1:0] tor_hi;
    logic [BW-1:0] na4_lo;
    logic [BW-1:0] pot_t;
    logic [BW-1:0] pot_t1;

    always_comb begin
        tor_lo = {prev_addr, 2'b00};
        tor_hi = {this_addr, 2'b00} - BW'(1);
        na4_lo = {this_addr, 2'b00};
        pot_t  = {this_addr, 2'b11};
        pot_t1 = pot_t + BW'(1);
    end

    always_comb begin
        live = 1'b1;
        lo   = '0;
        hi   = '0;
        unique case (mode)
            RM_OFF: begin
                live = 1'b0;
            end
            RM_TOR: begin
                if (tor_lo > tor_hi) begin
                    lo = '0;
                    hi = '0;
                end else begin
                    lo = tor_lo;
                    hi = tor_hi;
                end
            end
            RM_NA4: begin
                lo = na4_lo;
                hi = na4_lo | BW'(3);
            end
            RM_NAPOT: begin
                lo = pot_t & pot_t1;
                hi = pot_t | pot_t1;
            end
            default: begin
                live = 1'b0;
            end
        endcase
    end

    logic [BW:0] span;
    always_comb begin
        span = {1'b0, hi} - {1'b0, lo} + (BW+1)'(1);
        if (live) begin
            AST_BOUNDS_ORDERED: assert (lo <= hi) else $error("region bounds inverted"); // R3
        end
        if (mode == RM_NAPOT) begin
            AST_NAPOT_POW2: assert ($onehot(span)) else $error("power-of-two span not a power of two"); // R5
        end
        if (mode == RM_NA4) begin
            AST_NA4_SPAN: assert (span == (BW+1)'(4)) else $error("four-byte region span wrong"); // R4
        end
    end

endmodule

// File: rtl/prm_range_probe.sv
module prm_range_probe
    import prm_pkg::*;
#(
    parameter int BW = 34
) (
    input  logic            live,
    input  logic [BW-1:0]   lo,
    input  logic [BW-1:0]   hi,
    input  logic [BW-1:0]   first_b,
    input  logic [BW-1:0]   last_b,
    output probe_t          probe
);
    always_comb begin
        probe.live     = live;
        probe.first_in = (first_b >= lo) && (first_b <= hi);
        probe.last_in  = (last_b  >= lo) && (last_b  <= hi);
    end

    always_comb begin
        if (probe.first_in && probe.last_in && live) begin
            AST_FULL_INSIDE: assert (first_b >= lo && last_b <= hi) else $error("full probe outside bounds"); // R6
        end
    end

endmodule

// File: rtl/prm_priority_pick.sv
module prm_priority_pick
    import prm_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  probe_t [NREG-1:0] probes,
    output verdict_e          verdict,
    output logic [IW-1:0]     idx
);
    logic [NREG-1:0] stop_vec;

    for (genvar g = 0; g < NREG; g++) begin : g_stop
        assign stop_vec[g] = probe_stops(probes[g]);
    end

    // Scan from the top down so that the lowest stopping index is written last.
    always_comb begin
        verdict = VD_NONE;
        idx     = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (stop_vec[i]) begin
                verdict = probe_verdict(probes[i]);
                idx     = IW'(i);
            end
        end
    end

    always_comb begin
        if (verdict == VD_NONE) begin
            AST_NONE_NO_STOP: assert (stop_vec == '0) else $error("no-match while a region holds an end"); // R1
            AST_NONE_IDX_ZERO: assert (idx == '0) else $error("index nonzero on no-match"); // R9
        end else begin
            AST_WINNER_STOPS: assert (stop_vec[idx]) else $error("winner does not hold an end"); // R7
            for (int j = 0; j < NREG; j++) begin
                if (j < int'(idx)) begin
                    AST_LOWEST_WINS: assert (!stop_vec[j]) else $error("lower region skipped"); // R8
                end
            end
        end
    end

endmodule

// File: rtl/prot_region_matcher.sv
module prot_region_matcher
    import prm_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 32
) (
    input  logic [NREG*AW-1:0]        rgn_addr,
    input  logic [2*NREG-1:0]         rgn_mode,
    input  logic [AW+1:0]             acc_addr,
    input  logic [AW+1:0]             acc_len_m1,
    output logic [$clog2(NREG)-1:0]   hit_idx,
    output logic                      hit_full,
    output logic                      hit_partial,
    output logic                      hit_none
);
    localparam int BW = AW + 2;
    localparam int IW = $clog2(NREG);

    logic [BW-1:0] last_b;
    assign last_b = acc_addr + acc_len_m1;

    probe_t [NREG-1:0] probes;
    verdict_e          verdict;

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        logic [AW-1:0] prev_a;
        logic          live;
        logic [BW-1:0] lo;
        logic [BW-1:0] hi;

        if (g == 0) begin : g_first
            assign prev_a = '0;
        end else begin : g_chain
            assign prev_a = rgn_addr[AW*(g-1) +: AW];
        end

        prm_bounds_decoder #(.AW(AW)) u_dec (
            .mode      (rmode_e'(rgn_mode[2*g +: 2])),
            .this_addr (rgn_addr[AW*g +: AW]),
            .prev_addr (prev_a),
            .live      (live),
            .lo        (lo),
            .hi        (hi)
        );

        prm_range_probe #(.BW(BW)) u_probe (
            .live    (live),
            .lo      (lo),
            .hi      (hi),
            .first_b (acc_addr),
            .last_b  (last_b),
            .probe   (probes[g])
        );
    end

    prm_priority_pick #(.NREG(NREG), .IW(IW)) u_pick (
        .probes  (probes),
        .verdict (verdict),
        .idx     (hit_idx)
    );

    assign hit_full    = (verdict == VD_FULL);
    assign hit_partial = (verdict == VD_PART);
    assign hit_none    = (verdict == VD_NONE);

    always_comb begin
        AST_ONE_VERDICT: assert ($countones({hit_full, hit_partial, hit_none}) == 1) else $error("verdict flags not one-hot"); // R9
        if (rgn_mode == '0) begin
            AST_ALL_OFF_NONE: assert (hit_none) else $error("match with every region off"); // R1
        end
    end

endmodule

// File: tb/prot_region_matcher_bench.sv
module prot_region_matcher_bench;
    localparam int NREG = 8;
    localparam int AW   = 32;
    localparam int BW   = AW + 2;
    localparam int IW   = $clog2(NREG);
    localparam longint MASK = (64'd1 << BW) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [NREG*AW-1:0] rgn_addr   = '0;
    logic [2*NREG-1:0]  rgn_mode   = '0;
    logic [BW-1:0]      acc_addr   = '0;
    logic [BW-1:0]      acc_len_m1 = '0;
    logic [IW-1:0]      hit_idx;
    logic               hit_full;
    logic               hit_partial;
    logic               hit_none;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    prot_region_matcher #(.NREG(NREG), .AW(AW)) u_prot_region_matcher (
        .rgn_addr    (rgn_addr),
        .rgn_mode    (rgn_mode),
        .acc_addr    (acc_addr),
        .acc_len_m1  (acc_len_m1),
        .hit_idx     (hit_idx),
        .hit_full    (hit_full),
        .hit_partial (hit_partial),
        .hit_none    (hit_none)
    );

    // Behavioural reference: kind 0 none, 1 full, 2 partial.
    task automatic model(output int kind, output int idx);
        longint a, p, lo, hi, t, f, l;
        int m;
        bit fi, li;
        kind = 0;
        idx  = 0;
        f = longint'(acc_addr);
        l = (longint'(acc_addr) + longint'(acc_len_m1)) & MASK;
        for (int i = 0; i < NREG; i++) begin
            m = int'(rgn_mode[2*i +: 2]);
            a = longint'(rgn_addr[AW*i +: AW]);
            p = (i == 0) ? 0 : longint'(rgn_addr[AW*(i-1) +: AW]);
            if (m == 0) continue;
            if (m == 1) begin
                lo = (p << 2) & MASK;
                hi = ((a << 2) - 1) & MASK;
                if (lo > hi) begin lo = 0; hi = 0; end
            end else if (m == 2) begin
                lo = (a << 2) & MASK;
                hi = (lo + 3) & MASK;
            end else begin
                t  = ((a << 2) | 3) & MASK;
                lo = t & ((t + 1) & MASK);
                hi = (t | (t + 1)) & MASK;
            end
            fi = (f >= lo) && (f <= hi);
            li = (l >= lo) && (l <= hi);
            if (fi || li) begin
                kind = (fi && li) ? 1 : 2;
                idx  = i;
                return;
            end
        end
    endtask

    function automatic int dut_kind();
        if (hit_full && !hit_partial && !hit_none) return 1;
        if (!hit_full && hit_partial && !hit_none) return 2;
        if (!hit_full && !hit_partial && hit_none) return 0;
        return 3;
    endfunction

    task automatic compare(string tag, int ek, int ei);
        int ak;
        ak = dut_kind();
        checks++;
        if (ak != ek || int'(hit_idx) != ei) begin
            errors++;
            $display("FAIL %s: kind/idx actual %0d/%0d expected %0d/%0d (addr %h len-1 %h)",
                     tag, ak, hit_idx, ek, ei, acc_addr, acc_len_m1);
        end
    endtask

    // Drive just after a rising edge, check half a cycle later (same cycle: R10).
    task automatic probe(string tag, longint addr, longint lenm1, int ek, int ei);
        int mk, mi;
        @(posedge clk);
        #1;
        acc_addr   = BW'(addr);
        acc_len_m1 = BW'(lenm1);
        @(negedge clk);
        compare(tag, ek, ei);
        model(mk, mi);
        if (mk != ek || mi != ei) begin
            $display("model disagrees with directed expectation for %s", tag);
        end
    endtask

    task automatic set_rgn(int i, int m, longint a);
        rgn_mode[2*i +: 2]  = 2'(m);
        rgn_addr[AW*i +: AW] = AW'(a);
    endtask

    task automatic clear_all();
        rgn_mode = '0;
        rgn_addr = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Initial state: all regions off (R1, R9)
        @(negedge clk);
        compare("R1 initial all-off", 0, 0);

        // R1: off regions with nonzero addresses still never match
        for (int i = 0; i < NREG; i++) set_rgn(i, 0, 64'h40 + i);
        probe("R1 off regions ignored", 64'h100, 0, 0, 0);
        probe("R9 none idx zero", 64'h0, 64'hFF, 0, 0);

        // R2: TOR from 0 for region 0
        clear_all();
        set_rgn(0, 1, 64'h40);                 // 0x000..0x0FF
        probe("R2 tor region0 full", 64'h10, 3, 1, 0);
        probe("R7 tor straddle end", 64'hFE, 3, 2, 0);
        probe("R2 tor one past end", 64'h100, 0, 0, 0);

        // R2: previous address taken from an off region
        clear_all();
        set_rgn(0, 0, 64'h40);
        set_rgn(1, 1, 64'h80);                 // 0x100..0x1FF
        probe("R2 tor lower edge", 64'h100, 0, 1, 1);
        probe("R2 tor upper edge", 64'h1FF, 0, 1, 1);
        probe("R2 tor above", 64'h200, 0, 0, 0);
        probe("R2 tor below", 64'hFF, 0, 0, 0);

        // R3: inverted TOR collapses to byte 0
        clear_all();
        set_rgn(0, 0, 64'h10);
        set_rgn(1, 1, 64'h08);
        probe("R3 inverted covers byte0", 64'h0, 0, 1, 1);
        probe("R3 inverted partial", 64'h0, 1, 2, 1);
        probe("R3 inverted byte4 none", 64'h4, 0, 0, 0);

        // R4: four-byte region
        clear_all();
        set_rgn(2, 2, 64'h30);                 // 0xC0..0xC3
        probe("R4 na4 full", 64'hC0, 3, 1, 2);
        probe("R4 na4 straddle", 64'hC2, 3, 2, 2);
        probe("R4 na4 after", 64'hC4, 0, 0, 0);
        probe("R4 na4 before", 64'hBF, 0, 0, 0);

        // R5: power-of-two regions
        clear_all();
        set_rgn(3, 3, 64'h23);                 // 0x80..0x9F, 32 bytes
        probe("R5 napot k2 full", 64'h80, 64'h1F, 1, 3);
        probe("R5 napot k2 straddle top", 64'h9F, 1, 2, 3);
        probe("R5 napot k2 below", 64'h7F, 0, 0, 0);
        probe("R7 first outside last inside", 64'h7F, 1, 2, 3);
        set_rgn(3, 3, 64'h20);                 // 0x80..0x87, 8 bytes
        probe("R5 napot k0 top", 64'h87, 0, 1, 3);
        probe("R5 napot k0 past", 64'h88, 0, 0, 0);
        set_rgn(3, 3, 64'h27);                 // 0x80..0xBF, 64 bytes
        probe("R5 napot k3 top", 64'hBF, 0, 1, 3);
        probe("R5 napot k3 past", 64'hC0, 0, 0, 0);

        // R8: priority among overlapping regions
        clear_all();
        set_rgn(0, 2, 64'h20);                 // 0x80..0x83
        set_rgn(1, 3, 64'h23);                 // 0x80..0x9F
        probe("R8 low index wins full", 64'h80, 3, 1, 0);
        probe("R8 falls to next region", 64'h84, 0, 1, 1);
        probe("R8 partial at low index wins", 64'h82, 3, 2, 0);
        clear_all();
        set_rgn(5, 2, 64'h50);
        set_rgn(6, 2, 64'h50);
        probe("R8 equal regions pick lower", 64'h140, 0, 1, 5);

        // R6: last byte wraps modulo the address width
        clear_all();
        set_rgn(0, 1, 64'h0);                  // covers the whole space
        probe("R6 wrap full", MASK, 1, 1, 0);
        clear_all();
        set_rgn(0, 2, 64'h0);                  // 0x0..0x3
        probe("R6 wrap last in first out", MASK, 1, 2, 0);

        // Random mix compared with the reference model each cycle
        for (int n = 0; n < 1500; n++) begin
            int mk, mi;
            @(posedge clk);
            #1;
            for (int i = 0; i < NREG; i++) begin
                set_rgn(i, int'($urandom_range(0, 3)), longint'($urandom_range(0, 127)));
            end
            acc_addr   = BW'($urandom_range(0, 600));
            acc_len_m1 = BW'($urandom_range(0, 15));
            @(negedge clk);
            model(mk, mi);
            compare("R8 random vs model", mk, mi);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule